// File: doc/BRIEF.md
# Write Completion Status Reporter

This block sits on the read path of a paged nonvolatile memory, between the array read data and the byte-wide output bus. When no internal write is running, a read returns the array byte at the current address. While the internal write timer runs, every read becomes a status poll. The top bit returns the inverse of the top bit of the last byte that was written. The bit below it flips on each new read access. The remaining low bits still carry the array contents. The timer may have been started by a real write or by a write that protection blocked; the block does not tell these apart. Host software can watch either status bit to find out when the write has finished.

The read condition is decoded from the active-low chip select, output enable and write enable pins. A read is present when chip select and output enable are both low and write enable is high. The output enable is the tri-state control for the bus drivers. Both the data byte and its enable are registered, so they follow the pins with a latency of one clock. The toggle state advances once per read access, on the cycle the access begins. It clears to zero each time a new write cycle begins. This makes the first poll of every write cycle show a 1 in the toggle bit.

Top module: `wcs_reporter`

## Requirements
- R1: After synchronous reset, `bus_oe` is 0 and `bus_data` is all zeros.
- R2: `bus_oe` is 1 in the cycle after the pins show a read (`cs_n`=0, `oe_n`=0, `we_n`=1), and 0 in the cycle after any other pin combination.
- R3: In the cycle after `wr_busy` was 0, `bus_data` equals the `arr_data` of the previous cycle, on all bits.
- R4: In the cycle after `wr_busy` was 1, `bus_data[7]` equals the inverse of the previous cycle's `last_wr_data[7]`.
- R5: In the cycle after `wr_busy` was 1, `bus_data[5:0]` equals the previous cycle's `arr_data[5:0]`.
- R6: While `wr_busy` is 1, each read access start inverts the toggle state, and `bus_data[6]` shows the new value. In the first read of a write cycle it shows 1, then 0, then 1, and so on.
- R7: The toggle state changes only at a read access start. A read held for several cycles, idle cycles, and reads while not busy all leave `bus_data[6]` unchanged in the following busy polls.
- R8: A rising edge of `wr_busy` clears the toggle state. The first poll of a new write cycle therefore shows 1 in bit 6, whatever the previous cycle left. This also holds when the rise and the read start fall in the same cycle.
- R9: In the cycle after `wr_busy` falls, all bits of `bus_data` carry the true array data. No status value persists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| wr_busy | input | 1 | Internal write timer running |
| last_wr_data | input | DATA_W | Last byte written to the array |
| arr_data | input | DATA_W | Array data at the current address |
| bus_data | output | DATA_W | Registered byte for the output bus |
| bus_oe | output | 1 | Registered tri-state enable for the bus |

## Verification
Two events can land in the same cycle: a new write cycle clears the toggle, and a read access starts and advances it. The bench raises `wr_busy` in the exact cycle that a read begins. It does this right after a write cycle that left the toggle at 1, and it expects the bit to read 1, not 0. Sweeps over the data bytes and over all eight pin combinations, both busy and idle, check the other outputs against a per-cycle model.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

    typedef struct packed {
        logic act;    // read condition present this cycle
        logic start;  // first cycle of a read access
    } rd_evt_t;

    function automatic logic read_cond(input logic cs_n, input logic oe_n, input logic we_n);
        return !cs_n && !oe_n && we_n;
    endfunction

endpackage

// File: rtl/wcs_strobe.sv
module wcs_strobe
    import wcs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n,
    input  logic    oe_n,
    input  logic    we_n,
    output rd_evt_t evt
);
    logic rd_q;

    always_comb begin
        evt.act   = read_cond(cs_n, oe_n, we_n);
        evt.start = evt.act && !rd_q;
    end

    always_ff @(posedge clk) begin
        if (rst) rd_q <= 1'b0;
        else     rd_q <= evt.act;
    end

    // R7: a read access start is a single-cycle event
    p_start_single_r7: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> !evt.start);

endmodule

// File: rtl/wcs_toggle.sv
module wcs_toggle
    import wcs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    busy,
    input  rd_evt_t evt,
    output logic    tog_next
);
    logic tog_q;
    logic busy_q;
    logic busy_rise;
    logic tog_base;

    always_comb begin
        busy_rise = busy && !busy_q;
        tog_base  = busy_rise ? 1'b0 : tog_q;
        tog_next  = (busy && evt.start) ? !tog_base : tog_base;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tog_q  <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            tog_q  <= tog_next;
            busy_q <= busy;
        end
    end

    p_tog_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!evt.start && !busy_rise) |=> tog_q == $past(tog_q));

    p_tog_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_rise && !evt.start) |=> !tog_q);

    p_tog_first_r8: assert property (@(posedge clk) disable iff (rst)
        (busy_rise && evt.start) |=> tog_q);

    p_tog_flip_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && evt.start && !busy_rise) |=> tog_q != $past(tog_q));

endmodule

// File: rtl/wcs_outmux.sv
module wcs_outmux #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              rd_act,
    input  logic              tog_next,
    input  logic [DATA_W-1:0] last_wr_data,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_oe
);
    localparam int POLL_BIT = DATA_W - 1;
    localparam int TOG_BIT  = DATA_W - 2;

    logic [DATA_W-1:0] sel;

    always_comb begin
        sel = arr_data;
        if (busy) begin
            sel[POLL_BIT] = !last_wr_data[POLL_BIT];
            sel[TOG_BIT]  = tog_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_data <= '0;
            bus_oe   <= 1'b0;
        end else begin
            bus_data <= sel;
            bus_oe   <= rd_act;
        end
    end

    p_true_data_r3: assert property (@(posedge clk) disable iff (rst)
        !busy |=> bus_data == $past(arr_data));

    p_poll_bit_r4: assert property (@(posedge clk) disable iff (rst)
        busy |=> bus_data[POLL_BIT] == !$past(last_wr_data[POLL_BIT]));

    p_low_bits_r5: assert property (@(posedge clk) disable iff (rst)
        busy |=> bus_data[TOG_BIT-1:0] == $past(arr_data[TOG_BIT-1:0]));

endmodule

// File: rtl/wcs_reporter.sv
module wcs_reporter
    import wcs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              wr_busy,
    input  logic [DATA_W-1:0] last_wr_data,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_oe
);
    rd_evt_t evt;
    logic    tog_next;

    wcs_strobe u_strobe (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .oe_n (oe_n),
        .we_n (we_n),
        .evt  (evt)
    );

    wcs_toggle u_toggle (
        .clk      (clk),
        .rst      (rst),
        .busy     (wr_busy),
        .evt      (evt),
        .tog_next (tog_next)
    );

    wcs_outmux #(.DATA_W(DATA_W)) u_outmux (
        .clk          (clk),
        .rst          (rst),
        .busy         (wr_busy),
        .rd_act       (evt.act),
        .tog_next     (tog_next),
        .last_wr_data (last_wr_data),
        .arr_data     (arr_data),
        .bus_data     (bus_data),
        .bus_oe       (bus_oe)
    );

    p_oe_on_r2: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !oe_n && we_n) |=> bus_oe);

    p_oe_off_r2: assert property (@(posedge clk) disable iff (rst)
        (cs_n || oe_n || !we_n) |=> !bus_oe);

    p_release_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_busy) |=> bus_data == $past(arr_data));

endmodule

// File: tb/tb_wcs_reporter.sv
module tb_wcs_reporter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, wr_busy = 1'b0;
    logic [7:0] last_wr_data = '0, arr_data = '0;
    logic [7:0] bus_data;
    logic       bus_oe;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench model state
    logic m_prev_rd = 0, m_prev_busy = 0, m_tog = 0;

    always #10 clk = ~clk;

    wcs_reporter #(.DATA_W(8)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .wr_busy(wr_busy), .last_wr_data(last_wr_data), .arr_data(arr_data),
        .bus_data(bus_data), .bus_oe(bus_oe)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // drive one cycle (inputs already at negedge), then check at next negedge
    task automatic step(input logic c, input logic o, input logic w, input logic b,
                        input logic [7:0] ad, input logic [7:0] ld, input string tag);
        logic rd, st, base, nt;
        logic [7:0] exp;
        cs_n = c; oe_n = o; we_n = w; wr_busy = b; arr_data = ad; last_wr_data = ld;
        rd   = !c && !o && w;
        st   = rd && !m_prev_rd;
        base = (b && !m_prev_busy) ? 1'b0 : m_tog;
        nt   = (b && st) ? !base : base;
        exp  = b ? {!ld[7], nt, ad[5:0]} : ad;
        m_prev_rd = rd; m_prev_busy = b; m_tog = nt;
        @(posedge clk); @(negedge clk);
        chk({tag, " oe (R2)"}, {7'd0, bus_oe}, {7'd0, rd});
        chk(tag, bus_data, exp);
    endtask

    task automatic rd_pulse(input logic b, input logic [7:0] ad, input logic [7:0] ld, input string tag);
        step(0, 0, 1, b, ad, ld, tag);
        step(1, 1, 1, b, ad, ld, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 data", bus_data, 8'h00);
        chk("R1 oe", {7'd0, bus_oe}, 8'h00);
        rst = 1'b0;

        // R3: idle sweep over array bytes with all pin combinations
        for (int v = 0; v < 256; v++)
            step(v[0], v[1], v[2], 0, v[7:0], ~v[7:0], "R3");

        // R4/R5: busy sweep over bytes; toggle driven by pin pattern
        step(1, 1, 1, 0, 8'h00, 8'h00, "R3");
        for (int v = 0; v < 256; v++)
            step(v[0], v[1], v[2], 1, v[7:0] ^ 8'h5a, v[7:0], "R4/R5");

        // R9: busy falls, true data returns next cycle
        step(0, 0, 1, 0, 8'hc7, 8'h00, "R9");
        chk("R9 direct", bus_data, 8'hc7);

        // R6: fresh write cycle, polls show 1,0,1
        step(1, 1, 1, 1, 8'h00, 8'h80, "R8");
        rd_pulse(1, 8'h3f, 8'h80, "R6 first");
        step(0, 0, 1, 1, 8'h3f, 8'h80, "R6 second");
        chk("R6 second bit", {7'd0, bus_data[6]}, 8'h00);
        // R7: held read keeps bit 6
        step(0, 0, 1, 1, 8'h00, 8'h80, "R7 held");
        chk("R7 held bit", {7'd0, bus_data[6]}, 8'h00);
        step(1, 0, 1, 1, 8'h00, 8'h80, "R7 idle");
        step(0, 0, 1, 1, 8'h00, 8'h80, "R6 third");
        chk("R6 third bit", {7'd0, bus_data[6]}, 8'h01);
        // R7: read while not busy leaves toggle alone
        step(1, 1, 1, 0, 8'h00, 8'h00, "R7");
        rd_pulse(0, 8'h00, 8'h00, "R7 notbusy");

        // R8: previous cycle leaves toggle at 1; busy rise and read start same cycle
        step(1, 1, 1, 1, 8'h00, 8'h00, "R8");
        rd_pulse(1, 8'h00, 8'h00, "R8 setup");
        step(1, 1, 1, 0, 8'h00, 8'h00, "R8 gap");
        step(0, 0, 1, 1, 8'h00, 8'h00, "R8 same-cycle");
        chk("R8 same-cycle bit", bus_data, 8'hc0);

        // R1: reset mid-run clears outputs
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 rereset", {bus_oe, bus_data[6:0]}, 8'h00);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual=hung expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule